// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block models a synchronous burst SRAM with registered read data and single-cycle deselect. Each word is 18 bits wide and is split into two 9-bit byte lanes, and each lane carries its own parity bit. The depth is set by `ADDR_W`. The default is 10 bits so that elaboration stays small. Setting it to 16 gives the full 64K-word array. A bus master starts an access by pulling one of two address strobes low: a processor strobe or a controller strobe. That access may be a single beat, or it may be continued as a four-beat burst with the advance input.

All control inputs are sampled on the rising clock edge. The output enable is the one exception and acts without a clock. The data bus is split into `dIn` and `dOut`. The `dOutEn` flag says when the block drives the bus. The burst order is either linear or interleaved, chosen by the static `burstLinear` input. While the `sleep` input is high, the block ignores every access and keeps its contents.

Top module: `burst_sram`

## Requirements
- R1: A strobe cycle with all chip enables active (ce1N low, ce2 high, ce3N low) and no write request loads `addrIn` and reads it. The word appears on `dOut` after that rising edge, with `dOutEn` high.
- R2: If both strobes are low in one cycle, the processor strobe alone acts. A processor-strobe cycle is always a read, whatever the write inputs are, so memory is left unchanged.
- R3: The processor strobe is ignored while ce1N is high. The chip enables are evaluated only in a cycle that loads an address: inactive enables there deselect the block, and a deselected block neither reads nor writes. Enables that change on continuation cycles have no effect.
- R4: With gwN low, all lanes are written, whatever `bweN` and `bwN` are.
- R5: With gwN high and bweN low, bit i of `bwN` low writes lane i (`dIn[9i+8:9i]`). With bweN high, `bwN` writes nothing and the cycle is a read.
- R6: In linear order, burst beat k (0..3) addresses the low two bits (base+k) mod 4. Upper bits stay fixed. A beat is a cycle with no strobe and advN low.
- R7: In interleaved order, beat k addresses the low two bits base XOR k.
- R8: A cycle with no strobe and advN high repeats the access at the same address.
- R9: `dOutEn` = NOT oeN AND (a read was done at the previous edge). It reacts to oeN at once. Reset and the first read cycle after a deselect or a write give `dOutEn` low.
- R10: While sleep is high, no read, write, load or burst step happens. Memory and burst position are kept.
- R11: Write data is taken from `dIn` in the command cycle itself. It goes to the burst address that is current in that cycle, and continuation beats repeat the burst's access type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low reset of control state |
| addrIn | input | ADDR_W | Word address, taken on a load |
| adspN | input | 1 | Processor address strobe, active low |
| adscN | input | 1 | Controller address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| ce1N | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3N | input | 1 | Chip enable 3, active low |
| gwN | input | 1 | Global write, active low |
| bweN | input | 1 | Byte-write enable, active low |
| bwN | input | 2 | Per-lane write selects, active low |
| oeN | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep, active high |
| burstLinear | input | 1 | 1 selects linear order, 0 selects interleaved |
| dIn | input | 18 | Write data, two 9-bit lanes |
| dOut | output | 18 | Registered read data |
| dOutEn | output | 1 | High when the block drives the data bus |

## Verification
Several functions can collide in one cycle. Address-strobe priority can meet a write request, with both strobes low while gwN is low. The processor strobe can meet a high ce1N, where the controller strobe or the burst continuation must take over. Sleep can meet a write strobe. The bench drives each of these overlaps on purpose. Its scoreboard, built from the requirements, judges them by the read data that follows, and by reading back the location that must be left untouched. It also checks that after sleep the burst resumes at the expected beat.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  parameter int LANES  = 2;
  parameter int LANE_W = 9;

  // Per-cycle commands from the control to the datapath.
  typedef struct packed {
    logic             loadAddr;   // take addrIn as burst base, beat 0
    logic             stepBurst;  // advance beat counter
    logic             rdCycle;    // register the current word into dOut
    logic [LANES-1:0] wrLanes;    // lanes written this cycle
  } ramStrobes_t;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             adspN,
  input  logic             adscN,
  input  logic             advN,
  input  logic             ce1N,
  input  logic             ce2,
  input  logic             ce3N,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] bwN,
  input  logic             oeN,
  input  logic             sleep,
  output ramStrobes_t      strb,
  output logic             dOutEn
);
  logic selected, burstWrite, outActive;
  logic ceOk, procHit, ctrlHit, newAddr, wrReq, active, writeNow;
  logic [LANES-1:0] laneMask;

  always_comb begin
    ceOk     = !ce1N && ce2 && !ce3N;
    procHit  = !adspN && !ce1N;            // processor strobe gated by ce1
    ctrlHit  = !adscN && !procHit;         // controller strobe loses ties
    newAddr  = (procHit || ctrlHit) && !sleep;
    laneMask = !gwN ? '1 : (!bweN ? ~bwN : '0);
    wrReq    = |laneMask;
    active   = !sleep && (newAddr ? ceOk : selected);
    writeNow = newAddr ? (ctrlHit && wrReq) : burstWrite;
    strb.loadAddr  = newAddr && ceOk;
    strb.stepBurst = !sleep && !newAddr && selected && !advN;
    strb.rdCycle   = active && !writeNow;
    strb.wrLanes   = (active && writeNow) ? laneMask : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selected   <= 1'b0;
      burstWrite <= 1'b0;
      outActive  <= 1'b0;
    end else begin
      outActive <= strb.rdCycle;
      if (newAddr) begin
        selected <= ceOk;
        if (ceOk) burstWrite <= ctrlHit && wrReq;
      end
    end
  end

  assign dOutEn = !oeN && outActive;

  p_proc_reads_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !adspN && !ce1N) |-> (strb.wrLanes == '0));

  p_global_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !gwN && adspN && !adscN && !ce1N && ce2 && !ce3N) |-> (&strb.wrLanes));

  p_mask_after_deselect_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!selected && adspN && adscN) |=> !dOutEn);

  p_sleep_inert_r10: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> (strb.wrLanes == '0 && !strb.rdCycle && !strb.loadAddr && !strb.stepBurst));
endmodule

// File: rtl/burst_sram_dpath.sv
module burst_sram_dpath
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    burstLinear,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [LANES*LANE_W-1:0] dIn,
  input  ramStrobes_t             strb,
  output logic [LANES*LANE_W-1:0] dOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] baseAddr, nextBase, curAddr;
  logic [1:0]        cnt, nextCnt, lowBits;

  always_comb begin
    nextBase = strb.loadAddr ? addrIn : baseAddr;
    nextCnt  = strb.loadAddr ? 2'd0 : (strb.stepBurst ? cnt + 2'd1 : cnt);
    lowBits  = burstLinear ? (nextBase[1:0] + nextCnt) : (nextBase[1:0] ^ nextCnt);
    curAddr  = {nextBase[ADDR_W-1:2], lowBits};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      cnt      <= 2'd0;
    end else begin
      baseAddr <= nextBase;
      cnt      <= nextCnt;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneOut;
    always_ff @(posedge clk) begin
      if (strb.wrLanes[g]) laneMem[curAddr] <= dIn[g*LANE_W +: LANE_W];
      if (strb.rdCycle)    laneOut <= laneMem[curAddr];
    end
    assign dOut[g*LANE_W +: LANE_W] = laneOut;
  end

  p_beat_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepBurst |=> (cnt == $past(cnt) + 2'd1));

  p_hold_position_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadAddr && !strb.stepBurst) |=> ($stable(baseAddr) && $stable(cnt)));
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic                    adspN,
  input  logic                    adscN,
  input  logic                    advN,
  input  logic                    ce1N,
  input  logic                    ce2,
  input  logic                    ce3N,
  input  logic                    gwN,
  input  logic                    bweN,
  input  logic [LANES-1:0]        bwN,
  input  logic                    oeN,
  input  logic                    sleep,
  input  logic                    burstLinear,
  input  logic [LANES*LANE_W-1:0] dIn,
  output logic [LANES*LANE_W-1:0] dOut,
  output logic                    dOutEn
);
  ramStrobes_t strb;

  burst_sram_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .adspN(adspN), .adscN(adscN), .advN(advN),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .gwN(gwN), .bweN(bweN), .bwN(bwN),
    .oeN(oeN), .sleep(sleep), .strb(strb), .dOutEn(dOutEn)
  );

  burst_sram_dpath #(.ADDR_W(ADDR_W)) uDpath (
    .clk(clk), .rstN(rstN), .burstLinear(burstLinear), .addrIn(addrIn),
    .dIn(dIn), .strb(strb), .dOut(dOut)
  );
endmodule

// File: tb/burst_sram_test.sv
`timescale 1ns/1ps
module burst_sram_test;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic adspN = 1'b1, adscN = 1'b1, advN = 1'b1;
  logic ce1N = 1'b1, ce2 = 1'b0, ce3N = 1'b1;
  logic gwN = 1'b1, bweN = 1'b1;
  logic [1:0] bwN = 2'b11;
  logic oeN = 1'b0, sleep = 1'b0, linear = 1'b1;
  logic [17:0] dIn = '0;
  logic [17:0] dOut;
  logic dOutEn;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  typedef struct { logic [17:0] data; int due; string req; } expItem_t;
  expItem_t expQ[$];

  logic [17:0] refMem [0:(1<<AW)-1];
  logic [AW-1:0] mBase = '0;
  logic [1:0]    mCnt = 2'd0;
  logic          mSel = 1'b0, mWrite = 1'b0;

  burst_sram #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .adspN(adspN), .adscN(adscN),
    .advN(advN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .gwN(gwN), .bweN(bweN),
    .bwN(bwN), .oeN(oeN), .sleep(sleep), .burstLinear(linear), .dIn(dIn),
    .dOut(dOut), .dOutEn(dOutEn)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected read words as they come due.
  always @(negedge clk) begin
    if (rstN && expQ.size() > 0 && expQ[0].due == cyc) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (dOutEn !== 1'b1 || dOut !== it.data) begin
        errors++;
        $display("FAIL %s actual=%0h/en%0b expected=%0h/en1", it.req, dOut, dOutEn, it.data);
      end
    end
  end

  task automatic step();
    @(posedge clk); @(negedge clk); #1;
  endtask

  // kind: 0 no strobe, 1 processor, 2 controller, 3 both
  task automatic op(input int kind, input logic [AW-1:0] a, input logic c1n, input logic c2,
                    input logic c3n, input logic advn, input logic gn, input logic bwen,
                    input logic [1:0] bwn, input logic [17:0] d, input logic slp, input string req);
    logic [1:0] mask, lo;
    logic ok, ph, ch, na, act, w;
    logic [AW-1:0] ad;
    mask = !gn ? 2'b11 : (!bwen ? ~bwn : 2'b00);
    ok = !c1n && c2 && !c3n;
    ph = (kind == 1 || kind == 3) && !c1n;
    ch = (kind == 2 || kind == 3) && !ph;
    na = (ph || ch) && !slp;
    act = 1'b0; w = 1'b0;
    if (!slp) begin
      if (na) begin
        mSel = ok;
        if (ok) begin mBase = a; mCnt = 2'd0; mWrite = ch && (|mask); act = 1'b1; w = mWrite; end
      end else if (mSel) begin
        if (!advn) mCnt = mCnt + 2'd1;
        act = 1'b1; w = mWrite;
      end
    end
    if (act) begin
      lo = linear ? (mBase[1:0] + mCnt) : (mBase[1:0] ^ mCnt);
      ad = {mBase[AW-1:2], lo};
      if (w) begin
        if (mask[0]) refMem[ad][8:0]  = d[8:0];
        if (mask[1]) refMem[ad][17:9] = d[17:9];
      end else begin
        expQ.push_back('{data: refMem[ad], due: cyc + 1, req: req});
      end
    end
    adspN = !(kind == 1 || kind == 3);
    adscN = !(kind == 2 || kind == 3);
    addrIn = a; ce1N = c1n; ce2 = c2; ce3N = c3n; advN = advn;
    gwN = gn; bweN = bwen; bwN = bwn; dIn = d; sleep = slp;
    step();
  endtask

  task automatic wrC(input logic [AW-1:0] a, input logic [17:0] d, input string req);
    op(2, a, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, d, 1'b0, req);
  endtask
  task automatic rdC(input logic [AW-1:0] a, input string req);
    op(2, a, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, '0, 1'b0, req);
  endtask
  task automatic contR(input logic advn, input string req);
    op(0, '0, 1'b0, 1'b1, 1'b0, advn, 1'b1, 1'b1, 2'b11, '0, 1'b0, req);
  endtask
  task automatic contW(input logic [17:0] d, input string req);
    op(0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, d, 1'b0, req);
  endtask
  task automatic desel(input string req);
    op(2, '0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, '0, 1'b0, req);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    chk(dOutEn, 0, "R9 reset");

    // R11: write burst, data taken in each command cycle
    wrC(10'h010, 18'h21111, "R11");
    contW(18'h12222, "R11");
    contW(18'h03333, "R11");
    contW(18'h34444, "R11");
    wrC(10'h030, 18'h15a5a, "R1");
    desel("R9");
    chk(dOutEn, 0, "R9 after write/deselect");

    // R6: linear burst from base 1 -> 11,12,13,10
    rdC(10'h011, "R6");
    contR(1'b0, "R6"); contR(1'b0, "R6"); contR(1'b0, "R6");
    contR(1'b1, "R8 hold");

    // R4 / R5: lane writes
    wrC(10'h020, 18'h3ffff, "R4");
    op(2, 10'h020, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 18'h00155, 1'b0, "R5");
    op(2, 10'h020, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 18'h2aa00, 1'b0, "R5");
    op(2, 10'h020, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 18'h00000, 1'b0, "R5 no bwe");
    rdC(10'h020, "R5");
    op(2, 10'h021, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b10, 18'h25555, 1'b0, "R4");
    rdC(10'h021, "R4");

    // R2: both strobes with global write -> read only
    op(3, 10'h010, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 18'h0, 1'b0, "R2");
    rdC(10'h010, "R2");

    // R3: processor strobe with ce1N high is ignored; enables ignored mid-burst
    rdC(10'h011, "R3");
    op(1, 10'h030, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, '0, 1'b0, "R3");
    op(0, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, '0, 1'b0, "R3");
    desel("R3");
    chk(dOutEn, 0, "R9 mask after deselect");
    op(2, 10'h030, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 18'h0, 1'b0, "R3");
    contR(1'b0, "R3");
    chk(dOutEn, 0, "R3 deselected idle");
    rdC(10'h030, "R3");

    // R9: asynchronous output enable
    oeN = 1'b1; #1;
    chk(dOutEn, 0, "R9 oe high");
    oeN = 1'b0; #1;
    chk(dOutEn, 1, "R9 oe low");

    // R10: sleep ignores a write strobe and freezes the burst
    rdC(10'h010, "R10");
    op(2, 10'h030, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 18'h0, 1'b1, "R10");
    chk(dOutEn, 0, "R10 sleep output");
    contR(1'b0, "R10");
    rdC(10'h030, "R10");

    // R7: interleaved burst from base 1 -> 11,10,13,12
    desel("R7");
    linear = 1'b0;
    rdC(10'h011, "R7");
    contR(1'b0, "R7"); contR(1'b0, "R7"); contR(1'b0, "R7");

    // R1: single read through the processor strobe
    op(1, 10'h012, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, '0, 1'b0, "R1");
    desel("R1");
    desel("R1");
    chk(expQ.size(), 0, "R1 scoreboard drained");
    summary();
  end
endmodule